// File: doc/BRIEF.md
# SPI Target with Double-Buffered Transmit

This block is the target (slave) end of a byte-wide SPI link, attached to a small synchronous CPU register port. The external master owns the serial clock. The block samples SCK, chip select and MOSI into the system clock domain and finds the SCK edges there. In every byte frame it shifts one byte in and one byte out at the same time. Outgoing data passes through two stages. The CPU writes a holding register, and the block moves that byte into the transmit shift register only when no byte is in flight.

A transmit-ready flag tells software that the holding register can take a new byte. This flag comes out of reset set. It sets again each time the holding register hands its byte to the shift register. It does not mean that the serial frame has finished. The transmit interrupt request is a plain level: the flag AND its enable. Enabling the interrupt while the flag is set therefore asks for service at once. Software that does not want this clears the flag first.

On the receive side, a completed byte is copied into a receive data register and a receive-full flag sets. A read of the data register clears that flag. The serial timing is SPI mode 0, most significant bit first. Each SCK phase, high and low, must last at least four system clocks.

Top module: `spi_tgt_dualbuf`

## Requirements
- R1: The register map uses `bus_addr_i`. Address 0 writes the transmit holding register and reads the receive data register. Address 1 reads status: bit 0 is transmit-ready, bit 1 is receive-full. Address 2 reads and writes control: bit 0 is the transmit interrupt enable, bit 1 is the receive interrupt enable. Other bits read as 0.
- R2: After reset, transmit-ready is 1, receive-full is 0, both enables are 0, both interrupt outputs are low and `miso_o` is 1.
- R3: `irq_tx_o` is high exactly when transmit-ready and its enable are both 1. Setting the enable while the flag is 1 raises the request by the next cycle, with no data ever written.
- R4: Transmit-ready is cleared in two ways: a write to address 1 with bit 0 set, or a write to the holding register.
- R5: When the shift register is empty and no frame is in progress, a written byte moves into the shift register within two cycles and transmit-ready sets again. A second byte written after that waits in the holding register, and transmit-ready stays 0.
- R6: Shifting is full duplex, mode 0, MSB first. The first bit is on `miso_o` before the first rising SCK edge, and the output advances after each falling edge. MOSI is taken on rising edges. The byte sent is the one that was in the shift register when the frame began.
- R7: After the eighth rising edge, the received byte appears at address 0 and receive-full sets. A read of address 0 clears receive-full. `irq_rx_o` equals receive-full AND its enable.
- R8: A byte written to the holding register in the middle of a frame does not change the bits of that frame. It goes out in the next frame.
- R9: If nothing has been queued when a frame starts, the target sends 0xFF.
- R10: A holding-register write may fall in the same cycle as a move. The byte moved is then the earlier one, the newer byte stays held, and transmit-ready reads 0.
- R11: If chip select goes inactive in the middle of a frame, the partial byte is dropped. Receive-full does not set, the unsent transmit byte is discarded, and the next frame starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip select from the master, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| bus_wr_i | input | 1 | CPU write strobe |
| bus_rd_i | input | 1 | CPU read strobe (read side effects) |
| bus_addr_i | input | 2 | CPU register address |
| bus_wdata_i | input | DATA_W | CPU write data |
| bus_rdata_o | output | DATA_W | CPU read data for the addressed register |
| irq_tx_o | output | 1 | Transmit interrupt request (level) |
| irq_rx_o | output | 1 | Receive interrupt request (level) |

## Verification
Two functions can fall in the same cycle: a CPU write to the holding register, and the block's own move of the previous byte into the shift register. The bench provokes this on an idle link by writing two bytes on consecutive cycles, so that the second write lands on the edge where the first byte moves. It then judges the result three ways. Transmit-ready must read 0. The next frame must carry the first byte. The frame after that must carry the second byte. A full sweep of all 256 byte values, sent and received at once, confirms that shifting works for every value.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_STAT = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // bit positions inside status and control words
   localparam int ST_TXRDY  = 0;
   localparam int ST_RXFULL = 1;
   localparam int CT_TXIE   = 0;
   localparam int CT_RXIE   = 1;

   typedef struct packed {
      logic rx_ie;
      logic tx_ie;
   } ctrl_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_tgt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter #(
   parameter int               DATA_W    = 8,
   parameter bit               MSB_FIRST = 1'b1,
   parameter logic [DATA_W-1:0] FILL     = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sck_s_i,
   input  logic              csn_s_i,
   input  logic              mosi_s_i,
   input  logic              hold_full_i,
   input  logic [DATA_W-1:0] hold_data_i,
   output logic              move_o,
   output logic              mid_o,
   output logic              rx_done_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              miso_o
);

   localparam int               CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W-1);

   logic              sck_q, csn_q;
   logic              sel, rise, fall, cs_end, mid;
   logic [CNT_W-1:0]  cnt;
   logic              sh_full;
   logic [DATA_W-1:0] tx_sh, rx_sh;
   logic [DATA_W-1:0] tx_next, rx_next;
   logic              out_bit;

   assign sel    = ~csn_s_i;
   assign rise   = sel & sck_s_i & ~sck_q;
   assign fall   = sel & ~sck_s_i & sck_q;
   assign cs_end = csn_s_i & ~csn_q;
   assign mid    = (cnt != '0);

   // a byte may enter the shift register only between frames
   assign move_o = hold_full_i & ~sh_full & ~mid & ~rise;
   assign mid_o  = mid;

   if (MSB_FIRST) begin : g_msb
      assign tx_next = {tx_sh[DATA_W-2:0], 1'b1};
      assign rx_next = {rx_sh[DATA_W-2:0], mosi_s_i};
      assign out_bit = tx_sh[DATA_W-1];
   end else begin : g_lsb
      assign tx_next = {1'b1, tx_sh[DATA_W-1:1]};
      assign rx_next = {mosi_s_i, rx_sh[DATA_W-1:1]};
      assign out_bit = tx_sh[0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_q     <= 1'b0;
         csn_q     <= 1'b1;
         cnt       <= '0;
         sh_full   <= 1'b0;
         tx_sh     <= FILL;
         rx_sh     <= '0;
         rx_done_o <= 1'b0;
         rx_byte_o <= '0;
      end else begin
         sck_q     <= sck_s_i;
         csn_q     <= csn_s_i;
         rx_done_o <= 1'b0;
         if (cs_end) begin
            cnt <= '0;
            if (mid) begin
               sh_full <= 1'b0;
               tx_sh   <= FILL;
            end
         end else if (rise) begin
            rx_sh <= rx_next;
            if (cnt == LAST) begin
               cnt       <= '0;
               sh_full   <= 1'b0;
               tx_sh     <= FILL;
               rx_done_o <= 1'b1;
               rx_byte_o <= rx_next;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (fall && mid) begin
            tx_sh <= tx_next;
         end
         if (move_o) begin
            tx_sh   <= hold_data_i;
            sh_full <= 1'b1;
         end
      end
   end

   assign miso_o = out_bit;

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              move_i,
   input  logic              rx_done_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              hold_full_o,
   output logic [DATA_W-1:0] hold_data_o,
   output logic              tx_rdy_o,
   output logic              rx_full_o,
   output logic              irq_tx_o,
   output logic              irq_rx_o
);

   reg_sel_e          sel;
   logic              wr_data, wr_stat, wr_ctrl, rd_data;
   logic [DATA_W-1:0] rx_data;
   ctrl_t             ctrl;

   assign sel     = reg_sel_e'(addr_i);
   assign wr_data = wr_i & (sel == REG_DATA);
   assign wr_stat = wr_i & (sel == REG_STAT);
   assign wr_ctrl = wr_i & (sel == REG_CTRL);
   assign rd_data = rd_i & (sel == REG_DATA);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_rdy_o    <= 1'b1;
         hold_full_o <= 1'b0;
         hold_data_o <= '0;
         rx_full_o   <= 1'b0;
         rx_data     <= '0;
         ctrl        <= '0;
      end else begin
         // a fresh holding write outranks the set from a move
         if (wr_data)                        tx_rdy_o <= 1'b0;
         else if (move_i)                    tx_rdy_o <= 1'b1;
         else if (wr_stat && wdata_i[ST_TXRDY]) tx_rdy_o <= 1'b0;

         if (wr_data)     hold_full_o <= 1'b1;
         else if (move_i) hold_full_o <= 1'b0;
         if (wr_data)     hold_data_o <= wdata_i;

         if (rx_done_i)    rx_full_o <= 1'b1;
         else if (rd_data) rx_full_o <= 1'b0;
         if (rx_done_i)    rx_data   <= rx_byte_i;

         if (wr_ctrl) begin
            ctrl.tx_ie <= wdata_i[CT_TXIE];
            ctrl.rx_ie <= wdata_i[CT_RXIE];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         REG_DATA: rdata_o = rx_data;
         REG_STAT: begin
            rdata_o[ST_TXRDY]  = tx_rdy_o;
            rdata_o[ST_RXFULL] = rx_full_o;
         end
         REG_CTRL: begin
            rdata_o[CT_TXIE] = ctrl.tx_ie;
            rdata_o[CT_RXIE] = ctrl.rx_ie;
         end
         default: rdata_o = '0;
      endcase
   end

   assign irq_tx_o = tx_rdy_o & ctrl.tx_ie;
   assign irq_rx_o = rx_full_o & ctrl.rx_ie;

endmodule

// File: rtl/spi_tgt_dualbuf.sv
module spi_tgt_dualbuf
   import spi_tgt_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter bit               MSB_FIRST   = 1'b1,
   parameter logic [DATA_W-1:0] FILL       = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sck_i,
   input  logic              cs_ni,
   input  logic              mosi_i,
   output logic              miso_o,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_tx_o,
   output logic              irq_rx_o
);

   localparam int               PIN_W   = 3;
   localparam logic [PIN_W-1:0] PIN_RST = 3'b100;

   if (DATA_W < 4) begin : g_bad_width
      $error("spi_tgt_dualbuf: DATA_W must be at least 4");
   end

   logic [PIN_W-1:0]  pins_s;
   logic              move_w, mid_w, rx_done_w;
   logic [DATA_W-1:0] rx_byte_w, hold_data_w;
   logic              hold_full_w, tx_rdy_w, rx_full_w;

   spi_tgt_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_RST)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({cs_ni, sck_i, mosi_i}),
      .q_o   (pins_s)
   );

   spi_tgt_shifter #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST),
      .FILL     (FILL)
   ) u_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sck_s_i    (pins_s[1]),
      .csn_s_i    (pins_s[2]),
      .mosi_s_i   (pins_s[0]),
      .hold_full_i(hold_full_w),
      .hold_data_i(hold_data_w),
      .move_o     (move_w),
      .mid_o      (mid_w),
      .rx_done_o  (rx_done_w),
      .rx_byte_o  (rx_byte_w),
      .miso_o     (miso_o)
   );

   spi_tgt_regs #(
      .DATA_W(DATA_W)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bus_wr_i),
      .rd_i       (bus_rd_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .move_i     (move_w),
      .rx_done_i  (rx_done_w),
      .rx_byte_i  (rx_byte_w),
      .rdata_o    (bus_rdata_o),
      .hold_full_o(hold_full_w),
      .hold_data_o(hold_data_w),
      .tx_rdy_o   (tx_rdy_w),
      .rx_full_o  (rx_full_w),
      .irq_tx_o   (irq_tx_o),
      .irq_rx_o   (irq_rx_o)
   );

endmodule

// File: rtl/spi_tgt_dualbuf_chk.sv
module spi_tgt_dualbuf_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       bus_wr_i,
   input logic       bus_rd_i,
   input logic [1:0] bus_addr_i,
   input logic       move_i,
   input logic       mid_i,
   input logic       tx_rdy_i,
   input logic       rx_done_i,
   input logic       rx_full_i,
   input logic       irq_tx_i
);

   logic hold_wr, data_rd;
   assign hold_wr = bus_wr_i && (bus_addr_i == 2'd0);
   assign data_rd = bus_rd_i && (bus_addr_i == 2'd0);

   p_irq_needs_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_tx_i |-> tx_rdy_i);

   p_hold_wr_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_wr |=> !tx_rdy_i);

   p_move_sets_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (move_i && !hold_wr) |=> tx_rdy_i);

   p_single_move_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      move_i |=> !move_i);

   p_rx_done_sets_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_done_i |=> rx_full_i);

   p_read_clears_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_rd && !rx_done_i) |=> !rx_full_i);

   p_move_between_frames_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      move_i |-> !mid_i);

endmodule

bind spi_tgt_dualbuf spi_tgt_dualbuf_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .bus_wr_i  (bus_wr_i),
   .bus_rd_i  (bus_rd_i),
   .bus_addr_i(bus_addr_i),
   .move_i    (move_w),
   .mid_i     (mid_w),
   .tx_rdy_i  (tx_rdy_w),
   .rx_done_i (rx_done_w),
   .rx_full_i (rx_full_w),
   .irq_tx_i  (irq_tx_o)
);

// File: tb/spi_tgt_dualbuf_tb.sv
module spi_tgt_dualbuf_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_CTRL = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       miso, irq_tx, irq_rx;
   logic [7:0] rdata;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_tgt_dualbuf dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
      .miso_o(miso), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_tx_o(irq_tx), .irq_rx_o(irq_rx)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] mo, input bit inj, input logic [7:0] inj_v,
                       output logic [7:0] mi);
      @(negedge clk); cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
         mosi = mo[i];
         repeat (HALF) @(negedge clk);
         mi[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         if (inj && i == 4) cpu_wr(A_DATA, inj_v);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic partial(input logic [7:0] mo, input int nbits);
      @(negedge clk); cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = mo[i];
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   initial begin : main
      logic [7:0] d, mi;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state, R1 map
      cpu_rd(A_STAT, d); chk("R2 status after reset", d, 8'h01);
      cpu_rd(A_CTRL, d); chk("R1 control after reset", d, 8'h00);
      chk("R2 irq lines after reset", {6'b0, irq_rx, irq_tx}, 8'h00);
      chk("R2 miso idle", {7'b0, miso}, 8'h01);

      // R3 enabling with ready set requests at once
      cpu_wr(A_CTRL, 8'h01);
      chk("R3 irq_tx on enable", {7'b0, irq_tx}, 8'h01);
      // R4 software clear of ready
      cpu_wr(A_STAT, 8'h01);
      chk("R4 irq_tx after clear", {7'b0, irq_tx}, 8'h00);
      cpu_rd(A_STAT, d); chk("R4 status after clear", d, 8'h00);

      // R5 move into idle shifter
      cpu_wr(A_DATA, 8'h5A);
      repeat (2) @(negedge clk);
      cpu_rd(A_STAT, d); chk("R5 ready after move", d, 8'h01);
      chk("R5 irq_tx after move", {7'b0, irq_tx}, 8'h01);
      chk("R6 first bit on miso", {7'b0, miso}, 8'h00);
      cpu_wr(A_DATA, 8'hC3);
      repeat (2) @(negedge clk);
      cpu_rd(A_STAT, d); chk("R5 second byte waits", d, 8'h00);
      chk("R4 irq_tx after holding write", {7'b0, irq_tx}, 8'h00);

      // R6 full duplex, R7 receive path
      xfer(8'h3C, 1'b0, 8'h00, mi);
      chk("R6 byte sent", mi, 8'h5A);
      cpu_rd(A_STAT, d); chk("R7 full and R5 ready", d, 8'h03);
      chk("R7 irq_rx disabled", {7'b0, irq_rx}, 8'h00);
      cpu_wr(A_CTRL, 8'h02);
      chk("R7 irq_rx enabled", {7'b0, irq_rx}, 8'h01);
      cpu_rd(A_DATA, d); chk("R7 byte received", d, 8'h3C);
      cpu_rd(A_STAT, d); chk("R7 full cleared by read", d, 8'h01);
      chk("R7 irq_rx after read", {7'b0, irq_rx}, 8'h00);

      xfer(8'h81, 1'b0, 8'h00, mi);
      chk("R6 queued byte sent", mi, 8'hC3);
      cpu_rd(A_DATA, d); chk("R7 second byte received", d, 8'h81);

      // R9 nothing queued
      xfer(8'h42, 1'b0, 8'h00, mi);
      chk("R9 fill byte", mi, 8'hFF);
      cpu_rd(A_DATA, d); chk("R7 third byte received", d, 8'h42);

      // R8 write inside a frame
      xfer(8'h17, 1'b1, 8'h24, mi);
      chk("R8 frame unchanged by mid write", mi, 8'hFF);
      cpu_rd(A_DATA, d);
      xfer(8'h00, 1'b0, 8'h00, mi);
      chk("R8 mid write goes next frame", mi, 8'h24);
      cpu_rd(A_DATA, d); chk("R6 zero byte received", d, 8'h00);

      // R10 holding write in the move cycle
      @(negedge clk); addr = A_DATA; wdata = 8'h69; wr = 1'b1;
      @(negedge clk); wdata = 8'hB7;
      @(negedge clk); wr = 1'b0;
      repeat (2) @(negedge clk);
      cpu_rd(A_STAT, d); chk("R10 ready low after collision", d, 8'h00);
      xfer(8'hE1, 1'b0, 8'h00, mi);
      chk("R10 older byte sent first", mi, 8'h69);
      cpu_rd(A_DATA, d);
      xfer(8'h1E, 1'b0, 8'h00, mi);
      chk("R10 newer byte sent next", mi, 8'hB7);
      cpu_rd(A_DATA, d);

      // R11 abort in mid frame
      cpu_wr(A_DATA, 8'h96);
      repeat (2) @(negedge clk);
      partial(8'hF0, 3);
      cpu_rd(A_STAT, d); chk("R11 no receive flag after abort", d, 8'h01);
      xfer(8'hA7, 1'b0, 8'h00, mi);
      chk("R11 aborted byte discarded", mi, 8'hFF);
      cpu_rd(A_DATA, d); chk("R11 next frame starts at bit 7", d, 8'hA7);

      // sweep of all byte values, both directions
      for (int v = 0; v < 256; v++) begin
         logic [7:0] mo;
         mo = ~v[7:0] ^ 8'h35;
         cpu_wr(A_DATA, v[7:0]);
         repeat (2) @(negedge clk);
         xfer(mo, 1'b0, 8'h00, mi);
         chk("R6 sweep sent", mi, v[7:0]);
         cpu_rd(A_DATA, d);
         chk("R7 sweep received", d, mo);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule